// File: doc/BRIEF.md
# Exception Vector Address Generator

This block produces the 64-bit virtual address at which an exception handler starts. On each exception-request strobe it looks at the kind of exception, the address space of the faulting access and the per-space extended-addressing enables. One cycle later it presents the handler address together with a valid flag. The address is taken from one of two base regions, and the region is chosen by a bootstrap bit.

The block holds the bootstrap bit itself. Reset and NMI force the bit to 1, and software can rewrite it through a small status write port. The same port carries a byte-order control bit, which always reads back as 0 because only little-endian ordering is supported. Separately from the vector path, the block reports whether 64-bit extended opcodes are available at the current privilege level.

Top module: `exc_vector_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, the bootstrap bit reads 1, `vec_valid` is 0 and `vec_addr` is 0.
- R2: A cycle with `nmi` high sets the bootstrap bit to 1 from the next cycle on. This holds even if a status write in the same cycle carries 0.
- R3: A status write (`stat_we`) with no reset and no NMI in the same cycle loads `stat_boot_d` into the bootstrap bit, visible on `boot_q` from the next cycle. With no write, the bit holds its value.
- R4: `vec_valid` is high in exactly the cycle after each `exc_req` cycle. When no request comes, `vec_addr` keeps its last value.
- R5: For a general exception (`exc_class` = 0), the vector is 0xFFFFFFFF_BFC00380 when the effective bootstrap value is 1 and 0xFFFFFFFF_80000180 when it is 0. The effective value is 1 if `nmi` is high in the request cycle; otherwise it is the stored bit.
- R6: For a TLB refill (`exc_class` = 1) whose space is not extended, the vector is 0xFFFFFFFF_BFC00200 with the effective bootstrap value at 1 and 0xFFFFFFFF_80000000 with it at 0.
- R7: A TLB refill is extended, and its vector is the R6 address plus 0x080, when the enable for the faulting space is set. The `fault_seg` encoding is 0 = kernel (`kx_en`), 1 = supervisor (`sx_en`) and 2 = user (`ux_en`). Code 3 is never extended.
- R8: `ext_op_en` follows `cur_priv` in the same cycle. Kernel (0) gives 1 regardless of `kx_en`, supervisor (1) gives `sx_en`, user (2) gives `ux_en`, and code 3 gives 0.
- R9: `rev_endian` reads 0 at all times, including after a status write with `stat_rev_d` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request strobe |
| exc_class | input | 1 | 0 general, 1 TLB refill |
| fault_seg | input | 2 | Address space of the faulting access |
| cur_priv | input | 2 | Current privilege level |
| kx_en | input | 1 | Kernel extended-addressing enable |
| sx_en | input | 1 | Supervisor extended-addressing enable |
| ux_en | input | 1 | User extended-addressing enable |
| nmi | input | 1 | Non-maskable interrupt taken this cycle |
| stat_we | input | 1 | Status write strobe |
| stat_boot_d | input | 1 | Bootstrap bit write data |
| stat_rev_d | input | 1 | Byte-order bit write data |
| boot_q | output | 1 | Stored bootstrap bit |
| rev_endian | output | 1 | Byte-order bit, always 0 |
| ext_op_en | output | 1 | 64-bit extended opcodes allowed |
| vec_valid | output | 1 | Vector valid this cycle |
| vec_addr | output | 64 | Handler virtual address |

## Verification
The assertions check the following on every cycle:
- the bootstrap-bit updates and their priority (reset, then NMI, then the software write);
- the one-cycle valid timing and the holding of the address;
- the kernel opcode enable;
- that every vector keeps the all-ones upper word and 128-byte alignment.

The exact address for each combination of bootstrap value, class, faulting space and enable bit is shown only by the bench's scenarios, which compare against a reference model. The same applies to the NMI override of the stored bit in the request cycle and to the byte-order bit ignoring writes.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    localparam int VA_W   = 64;
    localparam int PRIV_W = 2;

    typedef enum logic {
        EXC_GENERAL = 1'b0,
        EXC_REFILL  = 1'b1
    } exc_class_e;

    typedef enum logic [PRIV_W-1:0] {
        LVL_KERNEL = 2'd0,
        LVL_SUPER  = 2'd1,
        LVL_USER   = 2'd2,
        LVL_RSVD   = 2'd3
    } level_e;

    typedef struct packed {
        logic boot;
        logic rev;
    } stat_wr_t;

    typedef struct packed {
        logic       boot;
        exc_class_e cls;
        logic       ext;
    } vec_sel_t;

    localparam logic [VA_W-1:0] BASE_BOOT = 64'hFFFF_FFFF_BFC0_0000;
    localparam logic [VA_W-1:0] BASE_NORM = 64'hFFFF_FFFF_8000_0000;
    localparam logic [VA_W-1:0] OFF_REFILL_BOOT = 64'h200;
    localparam logic [VA_W-1:0] OFF_REFILL_NORM = 64'h000;
    localparam logic [VA_W-1:0] OFF_GEN_BOOT    = 64'h380;
    localparam logic [VA_W-1:0] OFF_GEN_NORM    = 64'h180;
    localparam logic [VA_W-1:0] OFF_EXT_STEP    = 64'h080;

    localparam logic REV_SUPPORTED = 1'b0;

    function automatic logic [VA_W-1:0] vec_compose(input vec_sel_t s);
        logic [VA_W-1:0] base;
        logic [VA_W-1:0] off;
        base = s.boot ? BASE_BOOT : BASE_NORM;
        if (s.cls == EXC_REFILL) begin
            off = s.boot ? OFF_REFILL_BOOT : OFF_REFILL_NORM;
            if (s.ext) off = off + OFF_EXT_STEP;
        end else begin
            off = s.boot ? OFF_GEN_BOOT : OFF_GEN_NORM;
        end
        return base + off;
    endfunction

endpackage

// File: rtl/evg_status_reg.sv
module evg_status_reg
    import exc_vec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     nmi,
    input  logic     wr_en,
    input  stat_wr_t wr_data,
    output logic     boot_q,
    output logic     rev_q
);
    // Priority: reset, then NMI, then the software write.
    always_ff @(posedge clk) begin
        if (rst) begin
            boot_q <= 1'b1;
            rev_q  <= 1'b0;
        end else if (nmi) begin
            boot_q <= 1'b1;
        end else if (wr_en) begin
            boot_q <= wr_data.boot;
            rev_q  <= wr_data.rev & REV_SUPPORTED;
        end
    end
endmodule

// File: rtl/evg_mode_decode.sv
module evg_mode_decode
    import exc_vec_pkg::*;
(
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic [PRIV_W-1:0] fault_seg,
    input  logic              kx_en,
    input  logic              sx_en,
    input  logic              ux_en,
    output logic              ext_op_en,
    output logic              seg_ext
);
    localparam int NLVL = 1 << PRIV_W;

    logic [NLVL-1:0] xbits;
    assign xbits = {1'b0, ux_en, sx_en, kx_en};

    always_comb begin
        unique case (level_e'(cur_priv))
            LVL_KERNEL: ext_op_en = 1'b1;
            LVL_SUPER:  ext_op_en = sx_en;
            LVL_USER:   ext_op_en = ux_en;
            default:    ext_op_en = 1'b0;
        endcase
    end

    assign seg_ext = xbits[fault_seg];
endmodule

// File: rtl/evg_vec_calc.sv
module evg_vec_calc
    import exc_vec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  vec_sel_t        sel,
    output logic            valid,
    output logic [VA_W-1:0] addr
);
    logic [VA_W-1:0] addr_next;
    assign addr_next = vec_compose(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
        end else begin
            valid <= req;
            if (req) addr <= addr_next;
        end
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_vec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_req,
    input  logic            exc_class,
    input  logic [1:0]      fault_seg,
    input  logic [1:0]      cur_priv,
    input  logic            kx_en,
    input  logic            sx_en,
    input  logic            ux_en,
    input  logic            nmi,
    input  logic            stat_we,
    input  logic            stat_boot_d,
    input  logic            stat_rev_d,
    output logic            boot_q,
    output logic            rev_endian,
    output logic            ext_op_en,
    output logic            vec_valid,
    output logic [63:0]     vec_addr
);
    stat_wr_t wr;
    vec_sel_t sel;
    logic     seg_ext;

    assign wr.boot = stat_boot_d;
    assign wr.rev  = stat_rev_d;

    evg_status_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .nmi     (nmi),
        .wr_en   (stat_we),
        .wr_data (wr),
        .boot_q  (boot_q),
        .rev_q   (rev_endian)
    );

    evg_mode_decode u_dec (
        .cur_priv  (cur_priv),
        .fault_seg (fault_seg),
        .kx_en     (kx_en),
        .sx_en     (sx_en),
        .ux_en     (ux_en),
        .ext_op_en (ext_op_en),
        .seg_ext   (seg_ext)
    );

    // An NMI in the request cycle already selects the bootstrap region.
    assign sel.boot = boot_q | nmi;
    assign sel.cls  = exc_class_e'(exc_class);
    assign sel.ext  = seg_ext;

    evg_vec_calc u_calc (
        .clk   (clk),
        .rst   (rst),
        .req   (exc_req),
        .sel   (sel),
        .valid (vec_valid),
        .addr  (vec_addr)
    );
endmodule

// File: rtl/exc_vector_gen_chk.sv
module exc_vector_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        exc_req,
    input logic [1:0]  cur_priv,
    input logic        nmi,
    input logic        stat_we,
    input logic        stat_boot_d,
    input logic        boot_q,
    input logic        ext_op_en,
    input logic        vec_valid,
    input logic [63:0] vec_addr
);
    a_r1_reset_boot: assert property (@(posedge clk) rst |=> (boot_q && !vec_valid));

    a_r2_nmi_sets_boot: assert property (@(posedge clk) disable iff (rst)
        nmi |=> boot_q);

    a_r3_sw_write: assert property (@(posedge clk) disable iff (rst)
        (stat_we && !nmi) |=> (boot_q == $past(stat_boot_d)));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!stat_we && !nmi) |=> $stable(boot_q));

    a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> vec_valid);

    a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !exc_req |=> (!vec_valid && $stable(vec_addr)));

    a_r8_kernel_ext: assert property (@(posedge clk) disable iff (rst)
        (cur_priv == 2'd0) |-> ext_op_en);

    a_r7_vec_shape: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_addr[63:32] == 32'hFFFF_FFFF && vec_addr[6:0] == 7'd0));
endmodule

bind exc_vector_gen exc_vector_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .exc_req     (exc_req),
    .cur_priv    (cur_priv),
    .nmi         (nmi),
    .stat_we     (stat_we),
    .stat_boot_d (stat_boot_d),
    .boot_q      (boot_q),
    .ext_op_en   (ext_op_en),
    .vec_valid   (vec_valid),
    .vec_addr    (vec_addr)
);

// File: tb/exc_vector_gen_bench.sv
module exc_vector_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst, exc_req, exc_class, kx_en, sx_en, ux_en, nmi;
    logic        stat_we, stat_boot_d, stat_rev_d;
    logic [1:0]  fault_seg, cur_priv;
    logic        boot_q, rev_endian, ext_op_en, vec_valid;
    logic [63:0] vec_addr;

    int n_run = 0;
    int n_fail = 0;

    logic        m_boot;
    logic        e_valid;
    logic [63:0] e_addr;
    string       e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_vector_gen u_exc_vector_gen (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_class(exc_class),
        .fault_seg(fault_seg), .cur_priv(cur_priv), .kx_en(kx_en),
        .sx_en(sx_en), .ux_en(ux_en), .nmi(nmi), .stat_we(stat_we),
        .stat_boot_d(stat_boot_d), .stat_rev_d(stat_rev_d), .boot_q(boot_q),
        .rev_endian(rev_endian), .ext_op_en(ext_op_en),
        .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    function automatic logic [63:0] ref_vec(input logic b, input logic c,
                                            input logic [1:0] s, input logic k,
                                            input logic sv, input logic u);
        logic x;
        x = (s == 2'd0) ? k : (s == 2'd1) ? sv : (s == 2'd2) ? u : 1'b0;
        if (!c) return b ? 64'hFFFFFFFF_BFC00380 : 64'hFFFFFFFF_80000180;
        if (b)  return x ? 64'hFFFFFFFF_BFC00280 : 64'hFFFFFFFF_BFC00200;
        return x ? 64'hFFFFFFFF_80000080 : 64'hFFFFFFFF_80000000;
    endfunction

    function automatic logic ref_op(input logic [1:0] p, input logic sv, input logic u);
        return (p == 2'd0) ? 1'b1 : (p == 2'd1) ? sv : (p == 2'd2) ? u : 1'b0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Check the outputs of the previous edge, then drive one new cycle.
    task automatic cyc(input logic r, input logic q, input logic c, input logic [1:0] s,
                       input logic [1:0] p, input logic k, input logic sv, input logic u,
                       input logic n, input logic we, input logic bd, input logic rd);
        @(negedge clk);
        check(e_tag, {63'd0, vec_valid}, {63'd0, e_valid});
        if (e_valid || rst) check(e_tag, vec_addr, e_addr);
        check(stat_we ? "R3 boot" : "R2/R3 boot", {63'd0, boot_q}, {63'd0, m_boot});
        check("R9 rev", {63'd0, rev_endian}, 64'd0);
        check("R8 extop", {63'd0, ext_op_en}, {63'd0, ref_op(cur_priv, sx_en, ux_en)});
        rst = r; exc_req = q; exc_class = c; fault_seg = s; cur_priv = p;
        kx_en = k; sx_en = sv; ux_en = u; nmi = n; stat_we = we;
        stat_boot_d = bd; stat_rev_d = rd;
        #1;
        check("R8 extop", {63'd0, ext_op_en}, {63'd0, ref_op(p, sv, u)});
        if (r) begin
            e_valid = 1'b0; e_addr = 64'd0; e_tag = "R1 reset";
        end else begin
            e_valid = q;
            if (q) begin
                e_addr = ref_vec(m_boot | n, c, s, k, sv, u);
                e_tag = !c ? "R5 general" :
                        (ref_vec(1'b0, c, s, k, sv, u) != 64'hFFFFFFFF_80000000) ? "R7 ext refill" : "R6 refill";
            end else e_tag = "R4 hold";
        end
        m_boot = (r || n) ? 1'b1 : (we ? bd : m_boot);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; exc_req = 0; exc_class = 0; fault_seg = 0; cur_priv = 0;
        kx_en = 0; sx_en = 0; ux_en = 0; nmi = 0; stat_we = 0;
        stat_boot_d = 0; stat_rev_d = 0;
        m_boot = 1'b1; e_valid = 1'b0; e_addr = 64'd0; e_tag = "R1 reset";
        repeat (2) @(posedge clk);
        // Leave reset, probe R1 state; request general with boot=1 (R5)
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // boot=1 refill kernel, kx clear -> R6; kx set -> R7
        cyc(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        // software clears boot, writes rev=1 (R3, R9)
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1);
        cyc(0, 1, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 2'd1, 1, 0, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 2'd2, 2, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 1, 1, 2'd3, 3, 1, 1, 1, 0, 0, 0, 0);
        // NMI with simultaneous write of 0: NMI wins (R2), request sees boot region
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        // reset mid-run with a write of 0 (R1)
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [31:0] v;
            v = $urandom;
            cyc(v[31:28] == 4'd0, v[0], v[1], v[3:2], v[5:4], v[6], v[7], v[8],
                v[12:9] == 4'd0, v[15:13] == 3'd0, v[16], v[17]);
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule